// File: doc/BRIEF.md
# Serial Receiver with Aliased Framing-Error Flag

This block is the receive half of a classic 8-bit microcontroller serial port. It covers the asynchronous modes only: one 8-bit mode and two 9-bit modes. A baud tick at sixteen times the bit rate comes from outside. On each frame the block finds the start bit, recovers the data bits least significant bit first and checks the stop bit. It then raises a sticky receive flag in an 8-bit control/status register.

The top bit of that register has two meanings. When the select input is low it is the upper mode bit. When the select input is high it is a sticky framing-error flag. The select input also controls when the receive flag rises in the 9-bit modes. With the select low it rises during the ninth data bit. With the select high it waits for the stop bit, so the flag and the error state can be read together.

Control register layout (bit: meaning): 7 mode-high or framing error, 6 mode-low, 5 spare control, 4 receive enable, 3 spare control, 2 received ninth bit, 1 spare flag, 0 receive flag. The mode is {bit7 as mode-high, bit6}: 00 no reception, 01 8-bit, 10 and 11 9-bit.

Top module: `serial_rx_ctl`

## Requirements
- R1: After reset the control register reads 00h under either select value, and the received-data output is 00h.
- R2: A write to bit 7 with select high goes to the framing-error flag and leaves the mode-high bit unchanged. With select low it goes to the mode-high bit and leaves the flag unchanged. The bit 7 read value follows the same selection.
- R3: In mode 01 eight data bits are assembled, and in modes 10/11 nine bits are assembled, the first bit on the line being bit 0. Mode 00 receives nothing. The received-data output changes only when the receive flag is raised.
- R4: In modes 10/11 the ninth received bit is written to bit 2 (1 for a 1, 0 for a 0) when the receive flag is raised. In mode 01 bit 2 keeps its value.
- R5: A stop bit sampled as 0 in any receiving mode sets the framing-error flag. The flag stays set through later valid frames and through writes made with select low. It clears only on a write with select high and bit 7 at 0.
- R6: In mode 01 the receive flag rises during the stop bit under either select value.
- R7: In modes 10/11 the receive flag rises during the ninth data bit when select is low, and during the stop bit when select is high.
- R8: With bit 4 at 0 no frame is received, and the receive flag and received data do not change. Clearing bit 4 returns the receiver to idle.
- R9: A start bit is accepted only if a majority of three samples at oversampling ticks 7, 8 and 9 read 0. A short low glitch returns the receiver to idle, and the next real frame is received correctly.
- R10: The receive flag stays at 1 until software writes 0 to bit 0. Bits 6..0 are otherwise written as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| fe_sel_i | input | 1 | Selects framing-error flag (1) or mode-high bit (0) at bit 7 |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| ctl_o | output | 8 | Control register read value |
| rx_data_o | output | DATA_W | Last received data byte |

## Verification
Frames are sent in each of the 8-bit and 9-bit modes under both select values. This separates the ninth-bit receive point from the stop-bit receive point, which is observed at the end of the last data bit. Ninth-bit values of 1 and 0, and a mode 01 frame after software set bit 2, show whether the ninth bit is captured and whether bit 2 is left alone. Frames with a zero stop bit, followed by clean frames, writes with select low and writes with select high, show that the error flag is sticky and that its alias does not touch the mode bit. Frames sent with reception disabled, in mode 00, and after a short start glitch must produce no receive flag and no data change.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  localparam int unsigned BIT_RI    = 0;
  localparam int unsigned BIT_RB8   = 2;
  localparam int unsigned BIT_REN   = 4;
  localparam int unsigned BIT_SM1   = 6;
  localparam int unsigned BIT_ALIAS = 7;

  function automatic logic vote3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/serial_rx_bittimer.sv
module serial_rx_bittimer
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic rxd_i,
  output logic mid_o,
  output logic vote_o,
  output logic end_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned S0 = OSR / 2 - 1;
  localparam int unsigned S1 = OSR / 2;
  localparam int unsigned S2 = OSR / 2 + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      smp_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == CNT_W'(OSR - 1)) ? '0 : cnt_q + 1'b1;
      if (cnt_q == CNT_W'(S0)) smp_q[0] <= rxd_i;
      if (cnt_q == CNT_W'(S1)) smp_q[1] <= rxd_i;
    end
  end

  assign mid_o  = run_i & tick_i & (cnt_q == CNT_W'(S2));
  assign end_o  = run_i & tick_i & (cnt_q == CNT_W'(OSR - 1));
  assign vote_o = vote3(smp_q[0], smp_q[1], rxd_i);
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              fe_sel_i,
  input  logic              mid_i,
  input  logic              vote_i,
  input  logic              end_i,
  output logic              run_o,
  output logic              ri_evt_o,
  output logic              fe_set_o,
  output logic              rb8_ld_o,
  output logic              rb8_o,
  output logic [DATA_W-1:0] data_o,
  output rx_state_t         state_o
);
  localparam int unsigned SH_W  = DATA_W + 1;
  localparam int unsigned IDX_W = $clog2(SH_W);

  rx_state_t        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic [SH_W-1:0]  sh_q;
  logic             ninth_hit;
  logic             stop_hit;

  assign last_idx  = nine_i ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign ninth_hit = (state_q == RX_DATA) & mid_i & nine_i & ~fe_sel_i
                   & (idx_q == IDX_W'(DATA_W));
  assign stop_hit  = (state_q == RX_STOP) & mid_i;

  assign ri_evt_o = ninth_hit | (stop_hit & (~nine_i | fe_sel_i));
  assign fe_set_o = stop_hit & ~vote_i;
  assign rb8_ld_o = ri_evt_o & nine_i;
  assign rb8_o    = ninth_hit ? vote_i : sh_q[DATA_W];
  assign data_o   = sh_q[DATA_W-1:0];
  assign run_o    = (state_q != RX_IDLE);
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
    end else begin
      case (state_q)
        RX_IDLE: if (tick_i && !rxd_i) state_q <= RX_START;
        RX_START: begin
          if (mid_i && vote_i) state_q <= RX_IDLE;  // false start
          else if (end_i) begin
            state_q <= RX_DATA;
            idx_q   <= '0;
          end
        end
        RX_DATA: begin
          if (mid_i) sh_q[idx_q] <= vote_i;
          if (end_i) begin
            if (idx_q == last_idx) state_q <= RX_STOP;
            else idx_q <= idx_q + 1'b1;
          end
        end
        RX_STOP: if (mid_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              fe_sel_i,
  input  logic              ri_evt_i,
  input  logic              fe_set_i,
  input  logic              rb8_ld_i,
  input  logic              rb8_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [7:0]        ctl_o,
  output logic [DATA_W-1:0] rx_buf_o,
  output logic              sm0_o,
  output logic              sm1_o,
  output logic              ren_o,
  output logic              fe_o,
  output logic              ri_o
);
  logic              fe_q;
  logic              sm0_q;
  logic [6:0]        low_q;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fe_q  <= 1'b0;
      sm0_q <= 1'b0;
      low_q <= '0;
      buf_q <= '0;
    end else begin
      if (wr_i) begin
        if (fe_sel_i) fe_q  <= wdata_i[BIT_ALIAS];
        else          sm0_q <= wdata_i[BIT_ALIAS];
        low_q <= wdata_i[6:0];
      end
      // hardware events win over a same-cycle write
      if (fe_set_i) fe_q <= 1'b1;
      if (ri_evt_i) begin
        low_q[BIT_RI] <= 1'b1;
        buf_q         <= data_i;
      end
      if (rb8_ld_i) low_q[BIT_RB8] <= rb8_i;
    end
  end

  assign ctl_o    = {fe_sel_i ? fe_q : sm0_q, low_q};
  assign rx_buf_o = buf_q;
  assign sm0_o    = sm0_q;
  assign sm1_o    = low_q[BIT_SM1];
  assign ren_o    = low_q[BIT_REN];
  assign fe_o     = fe_q;
  assign ri_o     = low_q[BIT_RI];
endmodule

// File: rtl/serial_rx_ctl.sv
module serial_rx_ctl
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              fe_sel_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        ctl_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [1:0]        rxd_sync_q;
  logic              rxd_s;
  logic              run_w, mid_w, vote_w, end_w;
  logic              ri_evt_w, fe_set_w, rb8_ld_w, rb8_w;
  logic [DATA_W-1:0] sh_data_w;
  rx_state_t         state_w;
  logic              sm0_w, sm1_w, ren_w, fe_w, ri_w;
  logic              en_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_sync_q <= 2'b11;
    else         rxd_sync_q <= {rxd_sync_q[0], rxd_i};
  end
  assign rxd_s = rxd_sync_q[1];

  assign en_w = ren_w & (sm0_w | sm1_w);

  serial_rx_bittimer #(.OSR(OSR)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run_w),
    .rxd_i  (rxd_s),
    .mid_o  (mid_w),
    .vote_o (vote_w),
    .end_o  (end_w)
  );

  serial_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .rxd_i    (rxd_s),
    .en_i     (en_w),
    .nine_i   (sm0_w),
    .fe_sel_i (fe_sel_i),
    .mid_i    (mid_w),
    .vote_i   (vote_w),
    .end_i    (end_w),
    .run_o    (run_w),
    .ri_evt_o (ri_evt_w),
    .fe_set_o (fe_set_w),
    .rb8_ld_o (rb8_ld_w),
    .rb8_o    (rb8_w),
    .data_o   (sh_data_w),
    .state_o  (state_w)
  );

  serial_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .fe_sel_i (fe_sel_i),
    .ri_evt_i (ri_evt_w),
    .fe_set_i (fe_set_w),
    .rb8_ld_i (rb8_ld_w),
    .rb8_i    (rb8_w),
    .data_i   (sh_data_w),
    .ctl_o    (ctl_o),
    .rx_buf_o (rx_data_o),
    .sm0_o    (sm0_w),
    .sm1_o    (sm1_w),
    .ren_o    (ren_w),
    .fe_o     (fe_w),
    .ri_o     (ri_w)
  );
endmodule

// File: rtl/serial_rx_ctl_chk.sv
module serial_rx_ctl_chk
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [7:0]        reg_wdata_i,
  input logic              fe_sel_i,
  input logic              fe_i,
  input logic              sm0_i,
  input logic              ri_i,
  input logic              ren_i,
  input logic              ri_evt_i,
  input rx_state_t         state_i,
  input logic [DATA_W-1:0] rx_data_i
);
  assert_sm0_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && fe_sel_i |=> sm0_i == $past(sm0_i));

  assert_buf_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ri_evt_i |=> $stable(rx_data_i));

  assert_fe_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_i && !(reg_wr_i && fe_sel_i && !reg_wdata_i[BIT_ALIAS]) |=> fe_i);

  assert_ri_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_evt_i |-> (state_i == RX_DATA || state_i == RX_STOP));

  assert_ren_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_i |=> state_i == RX_IDLE);

  assert_ri_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_i && !(reg_wr_i && !reg_wdata_i[BIT_RI]) |=> ri_i);
endmodule

bind serial_rx_ctl serial_rx_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .fe_sel_i    (fe_sel_i),
  .fe_i        (fe_w),
  .sm0_i       (sm0_w),
  .ri_i        (ri_w),
  .ren_i       (ren_w),
  .ri_evt_i    (ri_evt_w),
  .state_i     (state_w),
  .rx_data_i   (rx_data_o)
);

// File: tb/serial_rx_ctl_tb.sv
module serial_rx_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       fe_sel_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] ctl_o;
  logic [7:0] rx_data_o;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [8:0] exp_q[$];

  serial_rx_ctl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .rxd_i       (rxd_i),
    .fe_sel_i    (fe_sel_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .ctl_o       (ctl_o),
    .rx_data_o   (rx_data_o)
  );

  always #10 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick_i = (c == 3);
      c = (c + 1) % 4;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] v);
    @(negedge clk);
    fe_sel_i = sel;
    reg_wdata_i = v;
    reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic line_bit(logic v);
    @(negedge clk);
    rxd_i = v;
    repeat (63) @(negedge clk);
  endtask

  task automatic send(int nb, logic [8:0] d, logic stopb, logic exp_ri,
                      logic exp_rb8, logic ri_at_last, string tag);
    if (exp_ri) exp_q.push_back({exp_rb8, d[7:0]});
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    check({tag, " RI at end of last data bit"}, 16'(ctl_o[0]), 16'(ri_at_last));
    line_bit(stopb);
    @(negedge clk);
    rxd_i = 1'b1;
    repeat (96) @(negedge clk);
    check({tag, " expected frames consumed"}, 16'(exp_q.size()), 16'd0);
    check({tag, " RI after frame"}, 16'(ctl_o[0]), 16'(exp_ri));
  endtask

  // monitor: scoreboard pop on each rising receive flag
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (ctl_o[0] && !prev) begin
        if (exp_q.size() == 0) begin
          n_run++;
          n_fail++;
          $display("FAIL R8 unexpected RI actual=1 expected=0");
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check("R3 received data", 16'(rx_data_o), 16'(e[7:0]));
          check("R4 ninth bit in bit 2", 16'(ctl_o[2]), 16'(e[8]));
        end
      end
      prev = ctl_o[0];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ctl sel0", 16'(ctl_o), 16'h00);
    check("R1 reset data", 16'(rx_data_o), 16'h00);
    fe_sel_i = 1'b1;
    #1 check("R1 reset ctl sel1", 16'(ctl_o), 16'h00);
    rst_ni = 1'b1;

    // mode 01
    wr(1'b0, 8'h50);
    check("R2 write readback", 16'(ctl_o), 16'h50);
    fe_sel_i = 1'b0;
    send(8, 9'h0A5, 1'b1, 1'b1, 1'b0, 1'b0, "R6 sel0");
    fe_sel_i = 1'b1;
    #1 check("R5 no error on valid stop", 16'(ctl_o), 16'h51);

    wr(1'b0, 8'h54);
    check("R10 RI cleared by write", 16'(ctl_o), 16'h54);
    fe_sel_i = 1'b1;
    send(8, 9'h03C, 1'b1, 1'b1, 1'b1, 1'b0, "R6 sel1");
    check("R4 bit 2 kept in mode 01", 16'(ctl_o[2]), 16'd1);

    wr(1'b1, 8'h54);
    send(8, 9'h00F, 1'b0, 1'b1, 1'b1, 1'b0, "R5 zero stop");
    check("R5 error flag set", 16'(ctl_o[7]), 16'd1);
    fe_sel_i = 1'b0;
    #1 check("R2 sel0 reads mode-high", 16'(ctl_o[7]), 16'd0);

    wr(1'b0, 8'h50);
    fe_sel_i = 1'b1;
    #1 check("R5 sel0 write keeps flag", 16'(ctl_o[7]), 16'd1);
    send(8, 9'h081, 1'b1, 1'b1, 1'b0, 1'b0, "R5 valid after error");
    check("R5 flag sticky over valid stop", 16'(ctl_o[7]), 16'd1);
    wr(1'b1, 8'h50);
    check("R5 flag cleared sel1 write", 16'(ctl_o), 16'h50);

    // mode 11
    wr(1'b0, 8'hD0);
    send(9, 9'h15A, 1'b1, 1'b1, 1'b1, 1'b1, "R7 sel0");
    check("R4 ctl after 9-bit frame", 16'(ctl_o), 16'hD5);
    wr(1'b0, 8'hD0);
    fe_sel_i = 1'b1;
    send(9, 9'h0C3, 1'b1, 1'b1, 1'b0, 1'b0, "R7 sel1");
    check("R4 ctl sel1 after frame", 16'(ctl_o), 16'h51);
    wr(1'b1, 8'h50);
    fe_sel_i = 1'b0;
    #1 check("R2 sel1 write keeps mode-high", 16'(ctl_o), 16'hD0);

    // mode 10, zero stop with early RI
    wr(1'b0, 8'h90);
    send(9, 9'h077, 1'b0, 1'b1, 1'b0, 1'b1, "R5 mode 10 zero stop");
    fe_sel_i = 1'b1;
    #1 check("R5 flag set in 9-bit mode", 16'(ctl_o[7]), 16'd1);
    wr(1'b1, 8'h10);
    fe_sel_i = 1'b0;
    #1 check("R2 mode kept after flag clear", 16'(ctl_o), 16'h90);

    // reception disabled
    wr(1'b0, 8'h40);
    send(8, 9'h0FF, 1'b1, 1'b0, 1'b0, 1'b0, "R8 disabled");
    check("R8 data unchanged", 16'(rx_data_o), 16'h77);

    // mode 00
    wr(1'b0, 8'h10);
    send(8, 9'h0EE, 1'b1, 1'b0, 1'b0, 1'b0, "R3 mode 00");
    check("R3 mode 00 data unchanged", 16'(rx_data_o), 16'h77);

    // false start then real frame
    wr(1'b0, 8'h50);
    @(negedge clk);
    rxd_i = 1'b0;
    repeat (8) @(negedge clk);
    rxd_i = 1'b1;
    repeat (160) @(negedge clk);
    check("R9 glitch gives no RI", 16'(ctl_o[0]), 16'd0);
    check("R9 glitch leaves data", 16'(rx_data_o), 16'h77);
    send(8, 9'h096, 1'b1, 1'b1, 1'b0, 1'b0, "R9 frame after glitch");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule